// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the configuration-space registers that describe message-signalled interrupts for one PCI function. It is built for a fixed feature set: 32- or 64-bit message address, optional per-vector masking, and a supported vector count that is a power of two from 1 to 32. The structure's length and the place of each field follow from that choice. The configuration port reads and writes whole dwords at byte offsets within the structure. Byte enables select the lanes, and a fixed write mask per field decides which bits software can change.

The dispatch logic reads the live values straight from the output ports: enable, message address and data, the log of the allocated vector count, the mask vector and the pending vector. The pending bits belong to the dispatch logic. It sets and clears them with strobes, and software can only read them. Any accepted write that leaves the function enabled also cleans up the state. An allocation larger than the supported count is pulled back to the supported count, and pending bits for vectors beyond the allocation are dropped.

Top module: `msi_cap_regs`

## Requirements
- R1: The structure is 0x0A bytes long for 32-bit without masking, 0x0E for 64-bit without masking, 0x14 for 32-bit with masking and 0x18 for 64-bit with masking. A dword whose aligned offset is at or beyond that length reads as zero, and a write to it changes no state.
- R2: Dword offsets are as follows. Offset 0 holds the control word in bits 31:16, and bits 15:0 read zero. Offset 4 holds the low address. In the 64-bit form, offset 8 holds the high address. The data field sits in bits 15:0 of offset 8 (32-bit) or 0x0C (64-bit), and bits 31:16 read zero. The mask register is at 0x0C or 0x10 and the pending register at 0x10 or 0x14.
- R3: Control word bits are: bit 0 enable, bits 3:1 log2 of the supported count, bits 6:4 log2 of the allocated count, bit 7 the 64-bit flag and bit 8 the masking flag. Only bit 0 and bits 6:4 are writable. Both lie in byte lane 2 of dword 0.
- R4: Bits 1:0 of the low address read zero. The high address is fully writable in the 64-bit form and zero otherwise. The 16-bit data field is fully writable.
- R5: Only mask bits below the supported vector count are stored. The bits above them read zero.
- R6: A write changes only the bytes whose byte-enable bit is set.
- R7: While reset is asserted, enable, the allocated-count log, both address words, data, mask and pending are all zero.
- R8: An in-range write that leaves enable set forces an allocated-count log above the supported log down to the supported log. A write that leaves enable clear keeps the written value.
- R9: An in-range write that leaves enable set clears every pending bit at or above the allocated count. The count used is the one after the clamp of R8, and the trim also drops bits set by a strobe in the same cycle.
- R10: Software cannot write the pending register. A set strobe turns a bit on and a clear strobe turns it off in the next cycle. If both strobe the same bit, set wins.
- R11: The output ports carry the register contents: the address as {high, low}, data, enable, the allocated-count log, mask and pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | OFFS_W | Byte offset within the structure (dword aligned) |
| cfg_be_i | input | 4 | Byte enables of the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for the dword at cfg_addr_i |
| pend_set_i | input | NUM_VEC | Pending set strobes from dispatch |
| pend_clr_i | input | NUM_VEC | Pending clear strobes from dispatch |
| msi_en_o | output | 1 | Message interrupts enabled |
| msi_addr_o | output | 64 | Message address |
| msi_data_o | output | 16 | Message data |
| vec_log_o | output | 3 | Log2 of the allocated vector count |
| vec_mask_o | output | NUM_VEC | Per-vector mask |
| vec_pend_o | output | NUM_VEC | Per-vector pending |

## Verification
A pending set strobe and a trimming configuration write can land in the same clock edge, and R9 decides which of the two wins. The bench provokes this in two ways. It raises set strobes on all vectors while writing the control word to a small allocation with enable on. It also repeats the same pair with enable off. In the first case only the bits inside the new allocation may survive. In the second case every strobed bit must remain. A reference model that applies the strobes first and the trim second judges the result, and the random phase mixes strobes and writes freely so that the same collision recurs at many allocation sizes.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_LOG_LSB = 4;

  function automatic int unsigned cap_len(bit addr64, bit pv_mask);
    case ({pv_mask, addr64})
      2'b00:   return 10;
      2'b01:   return 14;
      2'b10:   return 20;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl #(
  parameter int unsigned CAP_LOG = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_any_i,
  input  logic       wr_ctrl_i,
  input  logic       wd_en_i,
  input  logic [2:0] wd_log_i,
  output logic       en_o,
  output logic [2:0] log_o,
  output logic [2:0] log_next_o,
  output logic       trim_o
);
  localparam logic [2:0] CAP_LOG_L = 3'(CAP_LOG);

  logic       en_q, en_d;
  logic [2:0] log_q, log_d;

  always_comb begin
    en_d  = wr_ctrl_i ? wd_en_i  : en_q;
    log_d = wr_ctrl_i ? wd_log_i : log_q;
    // clamp only when the write leaves the function enabled
    if (wr_any_i && en_d && (log_d > CAP_LOG_L)) log_d = CAP_LOG_L;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      log_q <= 3'd0;
    end else begin
      en_q  <= en_d;
      log_q <= log_d;
    end
  end

  assign en_o       = en_q;
  assign log_o      = log_q;
  assign log_next_o = log_d;
  assign trim_o     = wr_any_i && en_d;
endmodule

// File: rtl/msi_cap_msg.sv
module msi_cap_msg #(
  parameter bit ADDR64 = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic        wr_data_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [63:0] addr_o,
  output logic [15:0] data_o
);
  logic [31:0] lo_q, lo_d;
  logic [31:0] hi_q;
  logic [15:0] data_q, data_d;

  always_comb begin
    lo_d = lo_q;
    for (int b = 0; b < 4; b++)
      if (wr_lo_i && be_i[b]) lo_d[8*b +: 8] = wdata_i[8*b +: 8];
    lo_d[1:0] = 2'b00;
    data_d = data_q;
    for (int b = 0; b < 2; b++)
      if (wr_data_i && be_i[b]) data_d[8*b +: 8] = wdata_i[8*b +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      data_q <= '0;
    end else begin
      lo_q   <= lo_d;
      data_q <= data_d;
    end
  end

  if (ADDR64) begin : g_hi
    logic [31:0] hi_d;
    always_comb begin
      hi_d = hi_q;
      for (int b = 0; b < 4; b++)
        if (wr_hi_i && be_i[b]) hi_d[8*b +: 8] = wdata_i[8*b +: 8];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hi_q <= '0;
      else         hi_q <= hi_d;
    end
  end else begin : g_no_hi
    logic unused_hi;
    assign unused_hi = wr_hi_i;
    assign hi_q = '0;
  end

  assign addr_o = {hi_q, lo_q};
  assign data_o = data_q;
endmodule

// File: rtl/msi_cap_vec.sv
module msi_cap_vec #(
  parameter bit          PV_MASK = 1'b1,
  parameter int unsigned NUM_VEC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] mask_we_i,
  input  logic [NUM_VEC-1:0] mask_wd_i,
  input  logic               trim_i,
  input  logic [2:0]         log_next_i,
  input  logic [NUM_VEC-1:0] set_i,
  input  logic [NUM_VEC-1:0] clr_i,
  output logic [NUM_VEC-1:0] mask_o,
  output logic [NUM_VEC-1:0] pend_o
);
  if (PV_MASK) begin : g_mask
    logic [NUM_VEC-1:0] mask_q, pend_q, pend_d, keep;

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_keep
      localparam logic [2:0] NEED = 3'($clog2(i + 1));
      assign keep[i] = (log_next_i >= NEED);
    end

    always_comb begin
      pend_d = (pend_q & ~clr_i) | set_i;
      if (trim_i) pend_d = pend_d & keep;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q <= '0;
        pend_q <= '0;
      end else begin
        for (int i = 0; i < int'(NUM_VEC); i++)
          if (mask_we_i[i]) mask_q[i] <= mask_wd_i[i];
        pend_q <= pend_d;
      end
    end

    assign mask_o = mask_q;
    assign pend_o = pend_q;
  end else begin : g_no_mask
    logic unused_vec;
    assign unused_vec = ^{mask_we_i, mask_wd_i, trim_i, log_next_i, set_i, clr_i,
                          clk_i, rst_ni};
    assign mask_o = '0;
    assign pend_o = '0;
  end
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter bit          ADDR64  = 1'b1,
  parameter bit          PV_MASK = 1'b1,
  parameter int unsigned NUM_VEC = 8,
  parameter int unsigned OFFS_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_wr_i,
  input  logic [OFFS_W-1:0]  cfg_addr_i,
  input  logic [3:0]         cfg_be_i,
  input  logic [31:0]        cfg_wdata_i,
  output logic [31:0]        cfg_rdata_o,
  input  logic [NUM_VEC-1:0] pend_set_i,
  input  logic [NUM_VEC-1:0] pend_clr_i,
  output logic               msi_en_o,
  output logic [63:0]        msi_addr_o,
  output logic [15:0]        msi_data_o,
  output logic [2:0]         vec_log_o,
  output logic [NUM_VEC-1:0] vec_mask_o,
  output logic [NUM_VEC-1:0] vec_pend_o
);
  localparam int unsigned       CAP_LOG  = $clog2(NUM_VEC);
  localparam logic [2:0]        CAP_LOG_L = 3'(CAP_LOG);
  localparam logic [OFFS_W-1:0] LEN_L    = OFFS_W'(cap_len(ADDR64, PV_MASK));
  localparam logic [OFFS_W-1:0] OFF_CTRL = OFFS_W'(0);
  localparam logic [OFFS_W-1:0] OFF_LO   = OFFS_W'(4);
  localparam logic [OFFS_W-1:0] OFF_HI   = OFFS_W'(8);
  localparam logic [OFFS_W-1:0] OFF_DATA = OFFS_W'(ADDR64 ? 12 : 8);
  localparam logic [OFFS_W-1:0] OFF_MASK = OFFS_W'(ADDR64 ? 16 : 12);
  localparam logic [OFFS_W-1:0] OFF_PEND = OFFS_W'(ADDR64 ? 20 : 16);

  logic [OFFS_W-1:0] dw_addr;
  logic in_range, wr_ok;
  logic wr_ctrl, wr_lo, wr_hi, wr_data, wr_mask;
  logic trim;
  logic [2:0] log_next;
  logic [NUM_VEC-1:0] mask_we;
  logic unused_ok;

  assign dw_addr   = {cfg_addr_i[OFFS_W-1:2], 2'b00};
  assign unused_ok = ^cfg_addr_i[1:0];
  assign in_range  = (dw_addr < LEN_L);
  assign wr_ok     = cfg_wr_i && in_range;
  assign wr_ctrl   = wr_ok && (dw_addr == OFF_CTRL) && cfg_be_i[2];
  assign wr_lo     = wr_ok && (dw_addr == OFF_LO);
  assign wr_hi     = wr_ok && ADDR64 && (dw_addr == OFF_HI);
  assign wr_data   = wr_ok && (dw_addr == OFF_DATA);
  assign wr_mask   = wr_ok && PV_MASK && (dw_addr == OFF_MASK);

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_mask_we
    assign mask_we[i] = wr_mask && cfg_be_i[i/8];
  end

  msi_cap_ctrl #(.CAP_LOG(CAP_LOG)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_any_i   (wr_ok),
    .wr_ctrl_i  (wr_ctrl),
    .wd_en_i    (cfg_wdata_i[16 + CTRL_EN_BIT]),
    .wd_log_i   (cfg_wdata_i[16 + CTRL_LOG_LSB +: 3]),
    .en_o       (msi_en_o),
    .log_o      (vec_log_o),
    .log_next_o (log_next),
    .trim_o     (trim)
  );

  msi_cap_msg #(.ADDR64(ADDR64)) i_msg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_lo_i   (wr_lo),
    .wr_hi_i   (wr_hi),
    .wr_data_i (wr_data),
    .be_i      (cfg_be_i),
    .wdata_i   (cfg_wdata_i),
    .addr_o    (msi_addr_o),
    .data_o    (msi_data_o)
  );

  msi_cap_vec #(.PV_MASK(PV_MASK), .NUM_VEC(NUM_VEC)) i_vec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mask_we_i  (mask_we),
    .mask_wd_i  (cfg_wdata_i[NUM_VEC-1:0]),
    .trim_i     (trim),
    .log_next_i (log_next),
    .set_i      (pend_set_i),
    .clr_i      (pend_clr_i),
    .mask_o     (vec_mask_o),
    .pend_o     (vec_pend_o)
  );

  logic [15:0] ctrl_word;
  assign ctrl_word = {7'd0, PV_MASK, ADDR64, vec_log_o, CAP_LOG_L, msi_en_o};

  always_comb begin
    cfg_rdata_o = '0;
    if (in_range) begin
      if (dw_addr == OFF_CTRL)                 cfg_rdata_o = {ctrl_word, 16'h0000};
      else if (dw_addr == OFF_LO)              cfg_rdata_o = msi_addr_o[31:0];
      else if (ADDR64 && dw_addr == OFF_HI)    cfg_rdata_o = msi_addr_o[63:32];
      else if (dw_addr == OFF_DATA)            cfg_rdata_o = {16'h0000, msi_data_o};
      else if (PV_MASK && dw_addr == OFF_MASK) cfg_rdata_o = 32'(vec_mask_o);
      else if (PV_MASK && dw_addr == OFF_PEND) cfg_rdata_o = 32'(vec_pend_o);
    end
  end
endmodule

// File: rtl/msi_cap_chk.sv
module msi_cap_chk
  import msi_cap_pkg::*;
#(
  parameter bit          ADDR64  = 1'b1,
  parameter bit          PV_MASK = 1'b1,
  parameter int unsigned NUM_VEC = 8,
  parameter int unsigned OFFS_W  = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_wr_i,
  input logic [OFFS_W-1:0]  cfg_addr_i,
  input logic [31:0]        cfg_rdata_o,
  input logic [NUM_VEC-1:0] pend_set_i,
  input logic [NUM_VEC-1:0] pend_clr_i,
  input logic               msi_en_o,
  input logic [63:0]        msi_addr_o,
  input logic [15:0]        msi_data_o,
  input logic [2:0]         vec_log_o,
  input logic [NUM_VEC-1:0] vec_mask_o,
  input logic [NUM_VEC-1:0] vec_pend_o
);
  localparam logic [2:0]        CAP_LOG_L = 3'($clog2(NUM_VEC));
  localparam logic [OFFS_W-1:0] LEN_L     = OFFS_W'(cap_len(ADDR64, PV_MASK));

  logic in_rng;
  assign in_rng = ({cfg_addr_i[OFFS_W-1:2], 2'b00} < LEN_L);

  a_r1_oob_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_rng |-> cfg_rdata_o == 32'd0);

  a_r1_oob_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && !in_rng && pend_set_i == '0 && pend_clr_i == '0) |=>
      ($stable(msi_addr_o) && $stable(msi_data_o) && $stable(msi_en_o) &&
       $stable(vec_log_o) && $stable(vec_mask_o) && $stable(vec_pend_o)));

  a_r4_addr_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_addr_o[1:0] == 2'b00);

  a_r4_no_high_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ADDR64 |-> msi_addr_o[63:32] == 32'd0);

  a_r8_clamped_when_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_en_o |-> vec_log_o <= CAP_LOG_L);

  a_r9_trimmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && in_rng) |=>
      (!msi_en_o || ((32'(vec_pend_o) >> (32'd1 << vec_log_o)) == 32'd0)));

  a_r10_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PV_MASK && !cfg_wr_i && pend_set_i != '0) |=>
      ((vec_pend_o & $past(pend_set_i)) == $past(pend_set_i)));

  a_r10_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_wr_i && pend_set_i == '0 && pend_clr_i == '0) |=> $stable(vec_pend_o));
endmodule

bind msi_cap_regs msi_cap_chk #(
  .ADDR64(ADDR64), .PV_MASK(PV_MASK), .NUM_VEC(NUM_VEC), .OFFS_W(OFFS_W)
) i_msi_cap_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_wr_i    (cfg_wr_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_rdata_o (cfg_rdata_o),
  .pend_set_i  (pend_set_i),
  .pend_clr_i  (pend_clr_i),
  .msi_en_o    (msi_en_o),
  .msi_addr_o  (msi_addr_o),
  .msi_data_o  (msi_data_o),
  .vec_log_o   (vec_log_o),
  .vec_mask_o  (vec_mask_o),
  .vec_pend_o  (vec_pend_o)
);

// File: tb/test_msi_cap_regs.sv
`timescale 1ns/100ps
module test_msi_cap_regs;
  localparam int NV = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_wr_i = 1'b0;
  logic [4:0]    cfg_addr_i = '0;
  logic [3:0]    cfg_be_i = '0;
  logic [31:0]   cfg_wdata_i = '0;
  logic [31:0]   cfg_rdata_o;
  logic [NV-1:0] pend_set_i = '0;
  logic [NV-1:0] pend_clr_i = '0;
  logic          msi_en_o;
  logic [63:0]   msi_addr_o;
  logic [15:0]   msi_data_o;
  logic [2:0]    vec_log_o;
  logic [NV-1:0] vec_mask_o;
  logic [NV-1:0] vec_pend_o;

  msi_cap_regs #(.ADDR64(1'b1), .PV_MASK(1'b1), .NUM_VEC(NV), .OFFS_W(5)) i_msi_cap_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i),
    .cfg_be_i(cfg_be_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
    .pend_set_i(pend_set_i), .pend_clr_i(pend_clr_i), .msi_en_o(msi_en_o),
    .msi_addr_o(msi_addr_o), .msi_data_o(msi_data_o), .vec_log_o(vec_log_o),
    .vec_mask_o(vec_mask_o), .vec_pend_o(vec_pend_o)
  );

  always #2 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit          m_en;
  logic [2:0]  m_log;
  logic [31:0] m_lo, m_hi;
  logic [15:0] m_data;
  logic [7:0]  m_mask, m_pend;

  function automatic logic [31:0] exp_rd(logic [4:0] a);
    logic [4:0] al = {a[4:2], 2'b00};
    case (al)
      5'd0:  return {7'd0, 1'b1, 1'b1, m_log, 3'd3, m_en, 16'h0000};
      5'd4:  return m_lo;
      5'd8:  return m_hi;
      5'd12: return {16'h0000, m_data};
      5'd16: return {24'h0, m_mask};
      5'd20: return {24'h0, m_pend};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_log = 0; m_lo = 0; m_hi = 0; m_data = 0; m_mask = 0; m_pend = 0;
  endtask

  task automatic model_step(bit wr, logic [4:0] a, logic [3:0] be, logic [31:0] d,
                            logic [7:0] set, logic [7:0] clr);
    logic [4:0] al = {a[4:2], 2'b00};
    bit hit = wr && (al < 5'd24);
    if (hit) begin
      case (al)
        5'd0:  if (be[2]) begin m_en = d[16]; m_log = d[22:20]; end
        5'd4:  begin
                 for (int b = 0; b < 4; b++) if (be[b]) m_lo[8*b +: 8] = d[8*b +: 8];
                 m_lo[1:0] = 2'b00;
               end
        5'd8:  for (int b = 0; b < 4; b++) if (be[b]) m_hi[8*b +: 8] = d[8*b +: 8];
        5'd12: for (int b = 0; b < 2; b++) if (be[b]) m_data[8*b +: 8] = d[8*b +: 8];
        5'd16: if (be[0]) m_mask = d[7:0];
        default: ;
      endcase
    end
    m_pend = (m_pend & ~clr) | set;
    if (hit && m_en) begin
      if (m_log > 3'd3) m_log = 3'd3;
      m_pend = m_pend & 8'((9'd1 << (4'd1 << m_log)) - 9'd1);
    end
  endtask

  task automatic check_outs(string req);
    chk(req, "enable", 64'(msi_en_o), 64'(m_en));
    chk(req, "log", 64'(vec_log_o), 64'(m_log));
    chk(req, "address", msi_addr_o, {m_hi, m_lo});
    chk(req, "data", 64'(msi_data_o), 64'(m_data));
    chk(req, "mask", 64'(vec_mask_o), 64'(m_mask));
    chk(req, "pending", 64'(vec_pend_o), 64'(m_pend));
  endtask

  // called right after a sampling point, well before the next falling edge
  task automatic rd_chk(string req, logic [4:0] a);
    cfg_addr_i = a;
    #0.5;
    chk(req, $sformatf("read@%h", a), 64'(cfg_rdata_o), 64'(exp_rd(a)));
  endtask

  task automatic op(bit wr, logic [4:0] a, logic [3:0] be, logic [31:0] d,
                    logic [7:0] set, logic [7:0] clr, string req);
    @(negedge clk_i);
    cfg_wr_i = wr; cfg_addr_i = a; cfg_be_i = be; cfg_wdata_i = d;
    pend_set_i = set; pend_clr_i = clr;
    @(posedge clk_i);
    model_step(wr, a, be, d, set, clr);
    #1;
    cfg_wr_i = 1'b0; pend_set_i = '0; pend_clr_i = '0;
    check_outs(req);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    model_reset();
    @(posedge clk_i); #1;
    check_outs("R7");
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    #1;
    check_outs("R7");
    do_reset();
    @(posedge clk_i); #1;
    rd_chk("R3", 5'd0);
    rd_chk("R2", 5'd4);
    rd_chk("R2", 5'd20);

    // field write masks
    op(1, 5'd4, 4'hF, 32'hFFFF_FFFF, 0, 0, "R4");
    rd_chk("R4", 5'd4);
    op(1, 5'd8, 4'hF, 32'h1234_5678, 0, 0, "R4");
    rd_chk("R4", 5'd8);
    op(1, 5'd12, 4'hF, 32'hFFFF_FFFF, 0, 0, "R4");
    rd_chk("R2", 5'd12);
    op(1, 5'd4, 4'b0010, 32'hAABB_CCDD, 0, 0, "R6");
    rd_chk("R6", 5'd4);
    op(1, 5'd8, 4'b1001, 32'h0000_0000, 0, 0, "R6");
    rd_chk("R11", 5'd8);

    // control word and clamp
    op(1, 5'd0, 4'hF, 32'hFFFF_FFFF, 0, 0, "R8");
    rd_chk("R3", 5'd0);
    op(1, 5'd0, 4'hB, 32'h0000_0000, 0, 0, "R6");
    op(1, 5'd0, 4'h4, 32'h0070_0000, 0, 0, "R8");
    chk("R8", "unclamped log", 64'(vec_log_o), 64'd7);
    op(1, 5'd12, 4'h1, 32'h0000_0042, 0, 0, "R8");
    op(1, 5'd0, 4'h4, 32'h0071_0000, 0, 0, "R8");
    chk("R8", "clamped log", 64'(vec_log_o), 64'd3);

    // mask
    op(1, 5'd16, 4'hF, 32'hFFFF_FFFF, 0, 0, "R5");
    rd_chk("R5", 5'd16);
    op(1, 5'd16, 4'hE, 32'h0000_0000, 0, 0, "R6");

    // pending
    op(0, 5'd0, 4'h0, 32'h0, 8'hA5, 8'h00, "R10");
    op(1, 5'd20, 4'hF, 32'h0000_0000, 0, 0, "R10");
    rd_chk("R10", 5'd20);
    op(0, 5'd0, 4'h0, 32'h0, 8'h01, 8'h81, "R10");
    chk("R10", "set beats clear", 64'(vec_pend_o), 64'h25);

    // collision of strobes and trim
    op(1, 5'd0, 4'h4, 32'h0011_0000, 8'hF3, 8'h00, "R9");
    chk("R9", "trim with set", 64'(vec_pend_o), 64'h03);
    op(1, 5'd0, 4'h4, 32'h0030_0000, 8'hFF, 8'h00, "R9");
    chk("R9", "no trim disabled", 64'(vec_pend_o), 64'hFF);
    op(1, 5'd0, 4'h4, 32'h0001_0000, 8'h00, 8'h00, "R9");
    chk("R9", "trim to one", 64'(vec_pend_o), 64'h01);

    // outside the structure
    op(1, 5'd24, 4'hF, 32'hFFFF_FFFF, 0, 0, "R1");
    op(1, 5'd28, 4'hF, 32'hFFFF_FFFF, 0, 0, "R1");
    rd_chk("R1", 5'd24);
    rd_chk("R1", 5'd31);

    // random mix
    void'($urandom(32'd20231));
    for (int n = 0; n < 400; n++) begin
      logic [4:0]  a  = 5'($urandom_range(0, 31));
      logic [3:0]  be = 4'($urandom);
      logic [31:0] d  = $urandom;
      logic [7:0]  st = 8'($urandom) & 8'($urandom);
      logic [7:0]  cl = 8'($urandom) & 8'($urandom);
      bit          wr = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 3) == 0) begin a = 5'd0; be = 4'h4; end
      op(wr, a, be, d, st, cl, "R11");
      rd_chk("R2", 5'($urandom_range(0, 31)));
    end

    do_reset();
    @(posedge clk_i); #1;
    rd_chk("R7", 5'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule